// File: doc/BRIEF.md
# Dictionary-Based Instruction Decompressor

This block sits between a compressed program memory and the fetch stage of a processor. The processor core is left as it is. It asks for instructions by byte address and receives full 32-bit native instructions. Program memory holds 32-bit words. Each word packs two 16-bit codes. Each code is an index into an on-chip dictionary of native instructions. The offline packer gives the lowest indices to the instructions that occur most often.

The block holds the most recently fetched memory word, tagged with the address it came from. When a request falls in that word, the instruction comes from the held word through a dictionary lookup, and program memory is not touched. Any other request starts a memory read and waits for the data. The block then keeps the returned word for later requests and produces the instruction from it. Decompression takes place on every fetch. The dictionary is a synchronous RAM. Software or boot logic fills it through a separate write port before execution starts.

The request side is a valid/ready stream. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while a memory read is outstanding. While it is low, the requester must hold `req_valid` and `req_addr` steady. The response side has no back-pressure: `rsp_valid` is high for exactly one cycle per accepted request, and the fetch unit must capture `rsp_instr` in that cycle.

Top module: `instr_unpacker`

## Requirements
- R1: During and right after active-low reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0, and the held word is marked empty, so the first request always misses.
- R2: A request is accepted on a cycle with `req_valid` and `req_ready` both high. `req_ready` is 0 exactly while a memory read is outstanding (`mem_req` high).
- R3: On a miss, `mem_req` rises in the cycle after acceptance with `mem_addr` equal to the accepted address. Both stay unchanged until a cycle in which `mem_rvalid` is 1.
- R4: In the cycle where `mem_req` and `mem_rvalid` are both 1, `mem_rdata` is captured as the held word. One cycle later `rsp_valid` is 1, and `rsp_instr` is the dictionary entry indexed by the low 8 bits of the selected code. The code is `mem_rdata[15:0]` when bit 2 of the missed address is 0, and `mem_rdata[31:16]` when it is 1.
- R5: A request is a hit when the held word is valid and address bits [31:3] equal those of the address that filled it. A hit never raises `mem_req`. `rsp_valid` follows one cycle after acceptance, with the dictionary entry for the code selected by bit 2 of the request address.
- R6: `rsp_valid` is 1 in exactly one cycle per accepted request, and only in the cycle after a hit acceptance or a fill. Back-to-back hits give one instruction per cycle.
- R7: A dictionary write (`dict_we`) to index k changes what later lookups of k return. A lookup issued in the same cycle as a write to its entry returns the old contents.
- R8: `mem_rvalid` while `mem_req` is 0 is ignored. It changes neither the held word nor `rsp_valid`, so a later request in the held word still hits with the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 32 | Byte address of the requested instruction |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_instr` is valid |
| rsp_instr | output | 32 | Decompressed native instruction |
| mem_req | output | 1 | Program memory read outstanding |
| mem_addr | output | 32 | Address of the outstanding read |
| mem_rvalid | input | 1 | Program memory read data valid |
| mem_rdata | input | 32 | Program memory read word (two codes) |
| dict_we | input | 1 | Dictionary write enable |
| dict_waddr | input | 8 | Dictionary write index |
| dict_wdata | input | 32 | Dictionary entry to write |

## Verification
Several request patterns are used. Sequential addresses, where pairs of requests share a word, separate the hit path from the miss path and test the choice of half-word by address bit 2. Back-to-back requests with `req_valid` held high test that a hit accepted in the response cycle of the previous request streams without a gap. Scattered addresses with low bits set and memory latencies from zero to several cycles show whether the tag ignores bits [2:0] and whether address and strobe are held until data returns. Two directed cases cover the rest: rewriting a dictionary entry and a stray memory data strobe during idle. They show whether the dictionary lookup is live and whether the held word is safe from unrequested data.

// File: rtl/unpacker_pkg.sv
package unpacker_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2
  } unpack_state_e;

  // byte offset bit that begins the per-instruction slot select
  localparam int unsigned INSTR_BYTE_LSB = 2;
endpackage

// File: rtl/dict_ram.sv
module dict_ram #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  // read returns contents from before a same-cycle write
  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
    if (we) store[waddr] <= wdata;
  end
endmodule

// File: rtl/word_holder.sv
module word_holder #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned TAG_LSB = 3,
  localparam int unsigned TAG_W  = ADDR_W - TAG_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [WORD_W-1:0] fill_word,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic [WORD_W-1:0] held_word
);
  logic             held_ok;
  logic [TAG_W-1:0] held_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_ok   <= 1'b0;
      held_tag  <= '0;
      held_word <= '0;
    end else if (fill) begin
      held_ok   <= 1'b1;
      held_tag  <= fill_addr[ADDR_W-1:TAG_LSB];
      held_word <= fill_word;
    end
  end

  assign hit = held_ok && (held_tag == look_addr[ADDR_W-1:TAG_LSB]);

  AST_FILL_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> (held_word == $past(fill_word))); // R4

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fill |=> $stable(held_word)); // R8
endmodule

// File: rtl/code_picker.sv
module code_picker #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CODE_W = 16,
  parameter int unsigned IDX_W  = 8,
  localparam int unsigned SLOTS = WORD_W / CODE_W,
  localparam int unsigned SEL_W = $clog2(SLOTS)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [SEL_W-1:0]  slot,
  output logic [IDX_W-1:0]  idx
);
  logic [CODE_W-1:0] codes [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign codes[g] = word[g*CODE_W +: CODE_W];
  end

  logic [CODE_W-1:0] chosen;
  assign chosen = codes[slot];
  assign idx    = chosen[IDX_W-1:0];
endmodule

// File: rtl/instr_unpacker.sv
module instr_unpacker
  import unpacker_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INSTR_W    = 32,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned CODE_W     = 16,
  parameter int unsigned DICT_DEPTH = 256,
  localparam int unsigned SLOTS     = WORD_W / CODE_W,
  localparam int unsigned SEL_W     = $clog2(SLOTS),
  localparam int unsigned IDX_W     = $clog2(DICT_DEPTH),
  localparam int unsigned SEL_LSB   = INSTR_BYTE_LSB,
  localparam int unsigned TAG_LSB   = SEL_LSB + SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic [INSTR_W-1:0] rsp_instr,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_rvalid,
  input  logic [WORD_W-1:0]  mem_rdata,
  input  logic               dict_we,
  input  logic [IDX_W-1:0]   dict_waddr,
  input  logic [INSTR_W-1:0] dict_wdata
);
  unpack_state_e     state, state_nx;
  logic [ADDR_W-1:0] prev_addr;
  logic              accept, hit, fill, look_re;
  logic [WORD_W-1:0] held_word, src_word;
  logic [SEL_W-1:0]  src_slot;
  logic [IDX_W-1:0]  look_idx;

  assign req_ready = (state != ST_FETCH);
  assign accept    = req_valid && req_ready;
  assign fill      = (state == ST_FETCH) && mem_rvalid;
  assign look_re   = fill || (accept && hit);
  assign rsp_valid = (state == ST_RESP);
  assign mem_req   = (state == ST_FETCH);
  assign mem_addr  = prev_addr;

  // after a fill the slot comes from the latched miss address
  assign src_word = fill ? mem_rdata : held_word;
  assign src_slot = fill ? prev_addr[SEL_LSB +: SEL_W] : req_addr[SEL_LSB +: SEL_W];

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_FETCH: if (mem_rvalid) state_nx = ST_RESP;
      default: begin
        if (accept) state_nx = hit ? ST_RESP : ST_FETCH;
        else        state_nx = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      prev_addr <= '0;
    end else begin
      state <= state_nx;
      if (accept && !hit) prev_addr <= req_addr;
    end
  end

  word_holder #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .TAG_LSB(TAG_LSB)) u_holder (
    .clk(clk), .rst_n(rst_n), .fill(fill), .fill_addr(prev_addr),
    .fill_word(mem_rdata), .look_addr(req_addr), .hit(hit), .held_word(held_word)
  );

  code_picker #(.WORD_W(WORD_W), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_pick (
    .word(src_word), .slot(src_slot), .idx(look_idx)
  );

  dict_ram #(.DEPTH(DICT_DEPTH), .DATA_W(INSTR_W)) u_dict (
    .clk(clk), .we(dict_we), .waddr(dict_waddr), .wdata(dict_wdata),
    .re(look_re), .raddr(look_idx), .rdata(rsp_instr)
  );

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready); // R2

  AST_MISS_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> (mem_req && mem_addr == $past(req_addr))); // R3

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R3

  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> !mem_req); // R5

  AST_RSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past((req_valid && req_ready) || (mem_req && mem_rvalid))); // R6

  AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid) |=> rsp_valid); // R4
endmodule

// File: tb/instr_unpacker_tb.sv
module instr_unpacker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, mem_req;
  logic [31:0] rsp_instr, mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        dict_we = 1'b0;
  logic [7:0]  dict_waddr = '0;
  logic [31:0] dict_wdata = '0;

  int vectors = 0;
  int fails   = 0;
  int lat     = 0;
  int cnt     = 0;
  int cycles  = 0;
  bit stray_tog = 1'b0;
  bit stray_ack = 1'b0;
  bit run_cmp   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_unpacker u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_instr(rsp_instr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .dict_we(dict_we), .dict_waddr(dict_waddr),
    .dict_wdata(dict_wdata)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [15:0] lo, hi;
    lo = a[18:3] ^ 16'h00A5;
    hi = a[18:3] * 16'd7 + 16'd1;
    return {hi, lo};
  endfunction

  function automatic logic [31:0] dict_init(input int i);
    return 32'hE000_0000 ^ (i * 32'h0001_0203);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] dict_m [256];
  bit          m_busy, m_rsp, m_hv;
  logic [31:0] m_paddr, m_word, m_inst;
  logic [28:0] m_tag;
  string       m_src = "R4";

  function automatic logic [31:0] pick(input logic [31:0] w, input bit b2);
    logic [15:0] c;
    c = b2 ? w[31:16] : w[15:0];
    return dict_m[c[7:0]];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_rsp = 0; m_hv = 0;
    end else begin
      bit nr;
      nr = 0;
      if (m_busy) begin
        if (mem_rvalid) begin
          m_hv = 1; m_tag = m_paddr[31:3]; m_word = mem_rdata;
          m_inst = pick(mem_rdata, m_paddr[2]); nr = 1; m_busy = 0; m_src = "R4";
        end
      end else if (req_valid) begin
        if (m_hv && m_tag == req_addr[31:3]) begin
          m_inst = pick(m_word, req_addr[2]); nr = 1; m_src = "R5";
        end else begin
          m_busy = 1; m_paddr = req_addr;
        end
      end
      if (dict_we) dict_m[dict_waddr] = dict_wdata;
      m_rsp = nr;
    end
  end

  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      check(req_ready == !m_busy, "R2 req_ready", 32'(req_ready), 32'(!m_busy));
      check(mem_req == m_busy, "R3 mem_req", 32'(mem_req), 32'(m_busy));
      if (m_busy) check(mem_addr == m_paddr, "R3 mem_addr", mem_addr, m_paddr);
      check(rsp_valid == m_rsp, "R6 rsp_valid", 32'(rsp_valid), 32'(m_rsp));
      if (m_rsp && rsp_valid) check(rsp_instr == m_inst, m_src, rsp_instr, m_inst);
    end
  end

  // ---------------- program memory model ----------------
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0; cnt <= 0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_rvalid <= 1'b1; mem_rdata <= mem_word(mem_addr); cnt <= 0;
      end else begin
        mem_rvalid <= 1'b0; cnt <= cnt + 1;
      end
    end else if (stray_tog != stray_ack) begin
      stray_ack <= stray_tog; mem_rvalid <= 1'b1; mem_rdata <= 32'hFFFF_FFFF; cnt <= 0;
    end else begin
      mem_rvalid <= 1'b0; cnt <= 0;
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++; vectors++;
      $display("FAIL watchdog R6: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [31:0] a);
    bit r;
    req_valid = 1'b1; req_addr = a;
    forever begin
      r = req_ready;
      @(negedge clk);
      if (r) break;
    end
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rsp(output logic [31:0] v);
    for (int k = 0; k < 50; k++) begin
      if (rsp_valid) break;
      @(negedge clk);
    end
    v = rsp_instr;
  endtask

  initial begin
    logic [31:0] got;
    logic [31:0] seed;
    int memreq_seen;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    // R7: load dictionary
    for (int i = 0; i < 256; i++) begin
      dict_we = 1'b1; dict_waddr = 8'(i); dict_wdata = dict_init(i);
      @(negedge clk);
    end
    dict_we = 1'b0;
    // R1: first request misses
    send(32'h0000_0100); req_valid = 1'b0;
    check(mem_req == 1'b1, "R1 first miss", 32'(mem_req), 32'd1);
    idle(3);
    // R5: same word, upper code
    send(32'h0000_0104); idle(2);
    send(32'h0000_0101); idle(2);
    lat = 3;
    send(32'h0000_010C); idle(8);
    // R6: streaming with valid held high
    for (int i = 0; i < 24; i++) begin
      lat = i % 4;
      send(32'h0000_0200 + 32'(i * 4));
    end
    idle(8);
    // scattered addresses, low bits set, gaps
    seed = 32'h1234_5678;
    for (int i = 0; i < 300; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      lat = int'(seed[27:26]) + (seed[5] ? 2 : 0);
      send({12'h0, 5'(seed[20:16]), 4'h0, seed[10:9] == 2'b00 ? 3'd0 : 3'(seed[8:6]), 8'(seed[15:11] & 5'h1F)});
      if (seed[30]) idle(int'(seed[3:2]));
    end
    idle(10);
    // R7: rewrite the entry used by word at 0x300 bit2=0
    lat = 1;
    send(32'h0000_0300); idle(6);
    dict_we = 1'b1; dict_waddr = mem_word(32'h300) [7:0]; dict_wdata = 32'hCAFE_F00D;
    @(negedge clk);
    dict_we = 1'b0;
    send(32'h0000_0300); req_valid = 1'b0;
    wait_rsp(got);
    check(got == 32'hCAFE_F00D, "R7 rewritten entry", got, 32'hCAFE_F00D);
    idle(3);
    // R8: stray strobe during idle is ignored
    stray_tog = ~stray_tog;
    idle(4);
    memreq_seen = 0;
    send(32'h0000_0304); req_valid = 1'b0;
    if (mem_req) memreq_seen++;
    wait_rsp(got);
    if (mem_req) memreq_seen++;
    check(memreq_seen == 0, "R8 no read after stray", 32'(memreq_seen), 32'd0);
    check(got == dict_init(int'(mem_word(32'h304) >> 16) & 255), "R8 held word kept", got,
          dict_init(int'(mem_word(32'h304) >> 16) & 255));
    idle(5);
    run_cmp = 1'b0;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule